// File: doc/BRIEF.md
# Serial Test-Chain Scan Sequencer

This block is the host end of a serial test-access chain. It produces the test clock, mode-select and data-in lines for a chain of devices, and it samples the chain's data-out line. A single-entry command port with valid/ready takes one of three requests: bring every device to its reset state, shift an instruction vector, or shift a data vector. For each request the block produces the complete mode-select walk through the standard sixteen-state test-port controller. It also keeps its own copy of that controller's state, so it always knows where every device in the chain is.

For a scan, the caller supplies a bit vector and a length. Bit 0 goes onto the chain first. The caller is responsible for building the chain-wide vector: the field of the device nearest the data-out pin sits in the low bits, each device's field is ordered least significant bit first, and a single filler bit stands for each device in bypass. The bits that come out of the chain during the shift are gathered into a capture vector. That vector is returned with a one-cycle done pulse.

The test clock is derived from the system clock by a divider. Mode-select and data-in change when the test clock falls. Data-out is sampled when it rises.

Top module: `jcs_top`

## Requirements
- R1: Operation code 0 produces exactly seven test-clock cycles with mode-select 1 and then stops. After that, `tap_state` reads 0 (reset state).
- R2: When the tracked state is reset (code 0), an instruction scan opens with the mode-select sequence 0,1,1,0,0. A data scan opens with 0,1,0,0.
- R3: When the tracked state is idle (code 1), an instruction scan opens with 1,1,0,0 and a data scan opens with 1,0,0. Whenever `cmd_ready` is high, `tap_state` is 0 or 1.
- R4: During a scan of N bits, data-in carries `cmd_bits[0]` through `cmd_bits[N-1]` in that order, one bit per test-clock cycle. Mode-select is 0 for the first N-1 of these cycles and 1 on the last. Two more cycles with mode-select 1 then 0 follow, and `tap_state` ends at 1 (idle).
- R5: `cap_bits[i]` holds data-out as sampled on the rising test-clock edge of the i-th shifted bit. Bits at and above N read 0.
- R6: The test clock is low at rest. Each of its half periods lasts HALF_DIV system clocks. `done` rises exactly 1 + 2·HALF_DIV·T system cycles after the accepting edge, where T is the number of test-clock cycles the command uses.
- R7: `done` is high for one cycle only. `cmd_ready` is low from the accepting edge until `done`. A `cmd_valid` that arrives while the block is busy is ignored and does not change the running command.
- R8: Operation codes 0 and 3 both request a reset. Code 1 is an instruction scan and code 2 is a data scan.
- R9: A length of 0 is treated as 1. A length above MAX_LEN is treated as MAX_LEN.
- R10: On a chain of three devices with 3-bit instruction registers, vectors built with the nearest-to-data-out field in the low bits select an 8-bit register in the middle device. Writing 0xF5 there through a 10-bit data scan (`cmd_bits` = 0x1EA) reads back 0x1EA on the next 10-bit data scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be taken |
| cmd_op | input | 2 | 0/3 reset, 1 instruction scan, 2 data scan |
| cmd_len | input | LEN_W | Scan length in bits |
| cmd_bits | input | MAX_LEN | Scan vector, bit 0 shifted first |
| tck | output | 1 | Generated test clock |
| tms | output | 1 | Mode-select to the chain |
| tdi | output | 1 | Serial data into the chain |
| tdo | input | 1 | Serial data out of the chain |
| done | output | 1 | One-cycle completion pulse |
| cap_bits | output | MAX_LEN | Bits sampled from the chain during the scan |
| tap_state | output | 4 | Tracked controller state (0 reset, 1 idle) |

## Verification
Each command's completion is due a fixed number of cycles after acceptance: one cycle for the start-up step, plus 2·HALF_DIV cycles for every test-clock cycle the expected mode-select walk contains. The bench works out that walk from the requirements before it issues the command. It then checks every system clock up to the predicted cycle that `done` stays low and `cmd_ready` stays low, and it requires `done` to be high exactly on that cycle. Each test-clock toggle must fall exactly HALF_DIV cycles after the previous one. The mode-select and data-in bits are recorded at each rising test-clock edge by a behavioural three-device chain model, and they are compared with the expected lists once the command completes. Capture vectors and the final tracked state are checked in the cycle of the done pulse.

// File: rtl/jcs_pkg.sv
package jcs_pkg;

  typedef enum logic [3:0] {
    TS_RESET    = 4'h0,
    TS_IDLE     = 4'h1,
    TS_SEL_DR   = 4'h2,
    TS_CAP_DR   = 4'h3,
    TS_SHIFT_DR = 4'h4,
    TS_EXIT1_DR = 4'h5,
    TS_PAUSE_DR = 4'h6,
    TS_EXIT2_DR = 4'h7,
    TS_UPD_DR   = 4'h8,
    TS_SEL_IR   = 4'h9,
    TS_CAP_IR   = 4'hA,
    TS_SHIFT_IR = 4'hB,
    TS_EXIT1_IR = 4'hC,
    TS_PAUSE_IR = 4'hD,
    TS_EXIT2_IR = 4'hE,
    TS_UPD_IR   = 4'hF
  } tap_state_t;

  localparam logic [1:0] OP_RESET = 2'd0;
  localparam logic [1:0] OP_IR    = 2'd1;
  localparam logic [1:0] OP_DR    = 2'd2;

  // One rising test-clock edge of the controller.
  function automatic tap_state_t tap_step(tap_state_t s, logic m);
    tap_state_t n;
    case (s)
      TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = m ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: n = m ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = m ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: n = m ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = m ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: n = m ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = m ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: n = m ? TS_UPD_IR   : TS_SHIFT_IR;
      default:     n = m ? TS_SEL_DR   : TS_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jcs_tck_div.sv
module jcs_tck_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_ev,
  output logic fall_ev
);
  logic hi_q;

  generate
    if (HALF_DIV <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst || !run) hi_q <= 1'b0;
        else             hi_q <= ~hi_q;
      end
      assign rise_ev = run && !hi_q;
      assign fall_ev = run &&  hi_q;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == LAST);
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt_q <= '0;
          hi_q  <= 1'b0;
        end else if (wrap) begin
          cnt_q <= '0;
          hi_q  <= ~hi_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign rise_ev = run && wrap && !hi_q;
      assign fall_ev = run && wrap &&  hi_q;
    end
  endgenerate

endmodule

// File: rtl/jcs_tap_track.sv
module jcs_tap_track
  import jcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       tms,
  output tap_state_t state
);
  logic [2:0] ones_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TS_RESET;
      ones_q <= 3'd0;
    end else if (step) begin
      state  <= tap_step(state, tms);
      ones_q <= tms ? ((ones_q == 3'd5) ? 3'd5 : ones_q + 3'd1) : 3'd0;
    end
  end

  // R1: five rising edges with mode-select high reach reset from anywhere
  p_ones_force_reset_r1: assert property (@(posedge clk) disable iff (rst)
    (ones_q == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/jcs_top.sv
module jcs_top
  import jcs_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int MAX_LEN  = 32,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [LEN_W-1:0]   cmd_len,
  input  logic [MAX_LEN-1:0] cmd_bits,
  output logic               tck,
  output logic               tms,
  output logic               tdi,
  input  logic               tdo,
  output logic               done,
  output logic [MAX_LEN-1:0] cap_bits,
  output logic [3:0]         tap_state
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic               busy_q, kick_q, smp_q;
  logic [6:0]         pre_q;
  logic [2:0]         pre_n_q;
  logic [MAX_LEN-1:0] sh_q;
  logic [LEN_W-1:0]   sh_n_q;
  logic [1:0]         post_n_q;
  logic [IDX_W-1:0]   idx_q;
  logic               rise_ev, fall_ev, advance, accept, is_scan, from_rst;
  logic [LEN_W-1:0]   len_eff;
  logic [6:0]         pre_pat;
  logic [2:0]         pre_cnt;
  tap_state_t         st;

  jcs_tck_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .run(busy_q && !kick_q),
    .rise_ev(rise_ev), .fall_ev(fall_ev));

  jcs_tap_track u_track (
    .clk(clk), .rst(rst), .step(rise_ev && busy_q), .tms(tms), .state(st));

  assign tap_state = st;
  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && !busy_q;
  assign advance   = kick_q || fall_ev;
  assign is_scan   = (cmd_op == OP_IR) || (cmd_op == OP_DR);
  assign from_rst  = (st == TS_RESET);

  always_comb begin
    if (cmd_len == '0)          len_eff = LEN_ONE;
    else if (cmd_len > LEN_MAX) len_eff = LEN_MAX;
    else                        len_eff = cmd_len;
  end

  // Opening mode-select walk, issued from bit 0 upward.
  always_comb begin
    unique case (cmd_op)
      OP_IR:   begin
        pre_pat = from_rst ? 7'b0000110 : 7'b0000011;
        pre_cnt = from_rst ? 3'd5 : 3'd4;
      end
      OP_DR:   begin
        pre_pat = from_rst ? 7'b0000010 : 7'b0000001;
        pre_cnt = from_rst ? 3'd4 : 3'd3;
      end
      default: begin
        pre_pat = 7'b1111111;
        pre_cnt = 3'd7;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; kick_q <= 1'b0; smp_q <= 1'b0; done <= 1'b0;
      tck <= 1'b0; tms <= 1'b0; tdi <= 1'b0;
      pre_q <= '0; pre_n_q <= '0; sh_q <= '0; sh_n_q <= '0;
      post_n_q <= '0; idx_q <= '0; cap_bits <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        kick_q   <= 1'b1;
        cap_bits <= '0;
        idx_q    <= '0;
        pre_q    <= pre_pat;
        pre_n_q  <= pre_cnt;
        sh_q     <= cmd_bits;
        sh_n_q   <= is_scan ? len_eff : '0;
        post_n_q <= is_scan ? 2'd2 : 2'd0;
      end else if (busy_q) begin
        kick_q <= 1'b0;
        if (rise_ev) begin
          tck <= 1'b1;
          if (smp_q) begin
            cap_bits[idx_q] <= tdo;
            idx_q           <= idx_q + 1'b1;
          end
        end
        if (advance) begin
          tck <= 1'b0;
          if (pre_n_q != '0) begin
            tms     <= pre_q[0];
            tdi     <= 1'b0;
            smp_q   <= 1'b0;
            pre_q   <= pre_q >> 1;
            pre_n_q <= pre_n_q - 1'b1;
          end else if (sh_n_q != '0) begin
            tms    <= (sh_n_q == LEN_ONE);
            tdi    <= sh_q[0];
            smp_q  <= 1'b1;
            sh_q   <= sh_q >> 1;
            sh_n_q <= sh_n_q - 1'b1;
          end else if (post_n_q != '0) begin
            tms      <= post_n_q[1];
            tdi      <= 1'b0;
            smp_q    <= 1'b0;
            post_n_q <= post_n_q - 1'b1;
          end else begin
            busy_q <= 1'b0;
            smp_q  <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: commands are only taken with the chain parked in reset or idle
  p_rest_state_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (st == TS_RESET || st == TS_IDLE));

  // R5: sampled bits come only from edges spent in a shift state
  p_shift_sample_r5: assert property (@(posedge clk) disable iff (rst)
    (rise_ev && busy_q && smp_q) |-> (st == TS_SHIFT_DR || st == TS_SHIFT_IR));

  // R6: the test clock rests low whenever no command is running
  p_tck_rest_r6: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !tck);

endmodule

// File: tb/tb_jcs_top.sv
`timescale 1ns/1ps
module tb_jcs_top;
  localparam int H  = 2;
  localparam int ML = 32;
  localparam int LW = $clog2(ML + 1);

  logic          clk = 1'b0, rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [LW-1:0] cmd_len = '0;
  logic [ML-1:0] cmd_bits = '0;
  logic          tck, tms, tdi, done;
  logic          tdo = 1'b0;
  logic [ML-1:0] cap_bits;
  logic [3:0]    tap_state;

  jcs_top #(.HALF_DIV(H), .MAX_LEN(ML)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_bits(cmd_bits),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .done(done),
    .cap_bits(cap_bits), .tap_state(tap_state));

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural three-device chain ----------------
  localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4,
                 S_E1DR = 5, S_PDR = 6, S_E2DR = 7, S_UPDR = 8, S_SELIR = 9,
                 S_CAPIR = 10, S_SHIR = 11, S_E1IR = 12, S_PIR = 13,
                 S_E2IR = 14, S_UPIR = 15;

  function automatic int nxt(int s, bit m);
    case (s)
      S_TLR:   return m ? S_TLR   : S_RTI;
      S_RTI:   return m ? S_SELDR : S_RTI;
      S_SELDR: return m ? S_SELIR : S_CAPDR;
      S_CAPDR, S_SHDR, S_E2DR: return m ? S_E1DR : S_SHDR;
      S_E1DR:  return m ? S_UPDR  : S_PDR;
      S_PDR:   return m ? S_E2DR  : S_PDR;
      S_UPDR, S_UPIR: return m ? S_SELDR : S_RTI;
      S_SELIR: return m ? S_TLR   : S_CAPIR;
      S_CAPIR, S_SHIR, S_E2IR: return m ? S_E1IR : S_SHIR;
      S_E1IR:  return m ? S_UPIR  : S_PIR;
      default: return m ? S_E2IR  : S_PIR;
    endcase
  endfunction

  int       bst = S_TLR;
  logic [2:0] ir [3], ir_sr [3];
  logic [7:0] dr [3], dr_sr [3];
  bit       tms_q[$], tdi_q[$], exp_q[$];

  initial for (int i = 0; i < 3; i++) begin
    ir[i] = 3'b111; ir_sr[i] = 3'b000; dr[i] = 8'h3C; dr_sr[i] = 8'h00;
  end

  always @(posedge tck) begin
    tms_q.push_back(tms);
    if (bst == S_SHIR || bst == S_SHDR) tdi_q.push_back(tdi);
    for (int i = 2; i >= 0; i--) begin
      logic inb;
      inb = (i == 0) ? tdi : ((bst == S_SHIR) ? ir_sr[i-1][0] : dr_sr[i-1][0]);
      case (bst)
        S_TLR:   ir[i] = 3'b111;
        S_CAPIR: ir_sr[i] = 3'b001;
        S_SHIR:  ir_sr[i] = {inb, ir_sr[i][2:1]};
        S_UPIR:  ir[i] = ir_sr[i];
        S_CAPDR: dr_sr[i] = (ir[i] == 3'b010) ? dr[i] : 8'h00;
        S_SHDR:  dr_sr[i] = (ir[i] == 3'b010) ? {inb, dr_sr[i][7:1]} : {7'b0, inb};
        S_UPDR:  if (ir[i] == 3'b010) dr[i] = dr_sr[i];
        default: ;
      endcase
    end
    bst = nxt(bst, tms);
  end

  always @(negedge tck)
    tdo <= (bst == S_SHIR) ? ir_sr[2][0] : (bst == S_SHDR) ? dr_sr[2][0] : 1'b0;

  // ---------------- half-period timing (R6) ----------------
  bit prev_tck = 1'b0, in_cmd = 1'b0;
  int last_tog = 0;
  always @(negedge clk) begin
    if (tck !== prev_tck) begin
      if (in_cmd) chk((cyc - last_tog) == H, "R6", "tck half period", cyc - last_tog, H);
      last_tog = cyc;
    end
    prev_tck = tck;
  end

  // ---------------- command driver and checks ----------------
  task automatic run_cmd(input logic [1:0] op, input int len, input logic [31:0] bits,
                         input logic [31:0] exp_cap, input bit from_tlr,
                         input int hold, input string req);
    int n, acc, exp_done, mm;
    bit rst_op;
    logic [31:0] mask;
    rst_op = (op == 2'd0 || op == 2'd3);
    n = (len < 1) ? 1 : ((len > ML) ? ML : len);
    exp_q.delete(); tms_q.delete(); tdi_q.delete();
    if (rst_op) repeat (7) exp_q.push_back(1'b1);
    else begin
      if (from_tlr) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
      if (op == 2'd1) exp_q.push_back(1'b1);
      exp_q.push_back(1'b0); exp_q.push_back(1'b0);
      repeat (n - 1) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1); exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    end
    @(negedge clk);
    cmd_op = op; cmd_len = LW'(len); cmd_bits = bits; cmd_valid = 1'b1;
    chk(cmd_ready === 1'b1, "R7", "ready at rest", cmd_ready, 1);
    acc = cyc + 1;
    exp_done = acc + 1 + 2 * H * exp_q.size();
    last_tog = acc + 1;
    in_cmd = 1'b1;
    forever begin
      @(negedge clk);
      if (hold > 0 && cyc == acc) begin cmd_op = 2'd2; cmd_len = LW'(5); cmd_bits = '1; end
      if (cyc - acc >= hold) cmd_valid = 1'b0;
      if (cyc < exp_done)
        chk(done === 1'b0 && cmd_ready === 1'b0, "R7", "busy without done",
            {done, cmd_ready}, 0);
      else begin
        chk(done === 1'b1 && cmd_ready === 1'b1, "R6", "done on predicted cycle",
            {done, cmd_ready}, 3);
        break;
      end
    end
    mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    if (!rst_op) chk(cap_bits === (exp_cap & mask), "R5", {req, " capture"}, cap_bits, exp_cap & mask);
    chk(tap_state === (rst_op ? 4'd0 : 4'd1), rst_op ? "R1" : "R4", {req, " final state"},
        tap_state, rst_op ? 0 : 1);
    mm = 0;
    foreach (exp_q[i]) if (i >= tms_q.size() || tms_q[i] != exp_q[i]) mm++;
    chk(mm == 0 && tms_q.size() == exp_q.size(), req, "mode-select walk", tms_q.size(), exp_q.size());
    if (!rst_op) begin
      mm = 0;
      for (int i = 0; i < n; i++) if (i >= tdi_q.size() || tdi_q[i] != bits[i]) mm++;
      chk(mm == 0 && tdi_q.size() == n, "R4", {req, " data-in order"}, tdi_q.size(), n);
    end
    @(negedge clk);
    chk(done === 1'b0, "R7", "done single cycle", done, 0);
    in_cmd = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready === 1'b1 && tck === 1'b0 && done === 1'b0, "R6", "rest outputs after reset",
        {cmd_ready, tck, done}, 4);
    chk(tap_state === 4'd0, "R1", "state after reset", tap_state, 0);

    // R1 / R8: reset command, code 0
    run_cmd(2'd0, 0, 32'h0, 32'h0, 1'b1, 0, "R1");
    // R2 / R10: instruction scan from reset, middle device selects its 8-bit register
    run_cmd(2'd1, 9, 32'h196, 32'h049, 1'b1, 0, "R2");
    // R3 / R10: data scan from idle writing 0xF5, old 0x3C comes back
    run_cmd(2'd2, 10, 32'h1EA, 32'h078, 1'b0, 0, "R3");
    // R10: read back the written value
    run_cmd(2'd2, 10, 32'h000, 32'h1EA, 1'b0, 0, "R10");
    // R4: one-bit scan, last bit is also the first
    run_cmd(2'd2, 1, 32'h1, 32'h0, 1'b0, 0, "R4");
    // R8: code 3 also resets
    run_cmd(2'd3, 0, 32'h0, 32'h0, 1'b0, 0, "R8");
    // R2 / R9: data scan from reset at full length through three bypass bits
    run_cmd(2'd2, 32, 32'hA5C3_1E69, 32'hA5C3_1E69 << 3, 1'b1, 0, "R2");
    // R3 / R9: instruction scan of length 40 clamped to 32
    run_cmd(2'd1, 40, 32'hFF81_2345, {23'(32'hFF81_2345), 9'h049}, 1'b0, 0, "R9");
    // R9: zero length behaves as one bit
    run_cmd(2'd2, 0, 32'h1, 32'h0, 1'b0, 0, "R9");
    // R7: valid held high with another command while busy is ignored
    run_cmd(2'd1, 9, 32'h196, 32'h049, 1'b0, 12, "R7");

    finish_run();
  end

endmodule